// File: doc/BRIEF.md
# Narrow-to-Wide AXI Command Translator

This block sits on the address channel between a narrow AXI master (32-bit or 64-bit data) and a 128-bit slave-side bus. For each read or write address command it decides whether the data path should pack narrow beats into full 128-bit beats (upsize) or carry one narrow transfer per wide beat (expand). It rewrites the size and length fields to match that decision. It also passes on the flag and the starting byte and slot position, so the data path knows where the first beat lands.

A command is upsized only when its modifiable cache bit is set, its burst is incrementing, and its size equals the full narrow width. For an upsized command the size becomes 16 bytes, and the length is recomputed to cover the same byte range, counted from the start byte inside the first 128-bit word. The start address is passed through unchanged, so both aligned and unaligned starts are covered. Every other command, including FIXED and WRAP bursts, keeps its size and length.

The command passes through one registered valid/ready stage. The stage is a two-state machine. In EMPTY it takes a command (transition ACCEPT, to FULL). In FULL it either holds while the slave stalls (STALL), hands its command on and takes the next in the same cycle (REFILL), or hands its command on and empties (DRAIN, to EMPTY).

Top module: `axi_cmd_widener`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1.
- R2: A command with `s_cache[1]`=1, `s_burst`=2'b01 (INCR) and `s_size`=log2(NARROW_BYTES) leaves with `m_packed`=1 and `m_size`=3'd4 (16 bytes).
- R3: For an upsized command that starts at a 16-byte boundary, `m_len` = ((len+1)*NARROW_BYTES + 15)/16 - 1.
- R4: For an upsized command with any start offset o = addr[3:0], `m_len` = ((o + (len+1)*NARROW_BYTES + 15) >> 4) - 1.
- R5: Any other command leaves with `m_packed`=0 and `m_size` and `m_len` equal to the input values. This includes cache bit 1 clear, FIXED (2'b00) or WRAP (2'b10) bursts, and sizes smaller than the narrow width.
- R6: `m_addr`, `m_burst` and `m_cache` equal the input values. `m_lane` = addr[3:0] is the start byte in the wide word, and `m_slot` = addr[3:log2(NARROW_BYTES)] is the start narrow slot.
- R7: While `m_valid`=1 and `m_ready`=0, `m_valid` stays 1 and every output field stays unchanged.
- R8: A command accepted at a clock edge is presented on `m_valid` after that edge. With `m_ready` held at 1, a new command is accepted every cycle without a bubble.
- R9: `s_ready` is 1 whenever the stage is empty or `m_ready` is 1. Commands leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Narrow-side command valid |
| s_ready | output | 1 | Narrow-side command ready |
| s_addr | input | ADDR_W | Command start address |
| s_len | input | LEN_W | Beats minus one |
| s_size | input | 3 | log2 of bytes per beat |
| s_burst | input | 2 | Burst type: 00 FIXED, 01 INCR, 10 WRAP |
| s_cache | input | 4 | Cache attributes; bit 1 is the modifiable bit |
| m_valid | output | 1 | Wide-side command valid |
| m_ready | input | 1 | Wide-side command ready |
| m_addr | output | ADDR_W | Start address, unchanged |
| m_len | output | LEN_W | Beats minus one after translation |
| m_size | output | 3 | Size after translation |
| m_burst | output | 2 | Burst type, unchanged |
| m_cache | output | 4 | Cache attributes, unchanged |
| m_packed | output | 1 | 1 = upsize, 0 = expand |
| m_lane | output | 4 | Start byte offset in the 128-bit word |
| m_slot | output | 4-log2(NARROW_BYTES) | Start narrow slot in the 128-bit word |

## Verification
The bench builds the block with NARROW_BYTES=4, ADDR_W=32 and LEN_W=8. This gives four narrow slots per wide word, so all four start offsets can be tried with a 2-bit slot field. The longest burst (len 255 from offset 12) reaches an upsized length of 64, which tests the top of the length arithmetic. The slave-ready pattern switches between always-ready, which exposes bubbles, and a periodic stall, which exposes lost, duplicated or altered commands.

// File: rtl/axi_widen_pkg.sv
package axi_widen_pkg;

    localparam int WIDE_BYTES = 16;
    localparam logic [2:0] WIDE_SIZE = 3'd4;

    localparam logic [1:0] BURST_FIXED = 2'b00;
    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0] BURST_WRAP  = 2'b10;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;

endpackage

// File: rtl/widen_decide.sv
module widen_decide
    import axi_widen_pkg::*;
#(
    parameter int LEN_W        = 8,
    parameter int NARROW_BYTES = 8
) (
    input  logic [3:0]       lane_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [2:0]       size_i,
    input  logic [1:0]       burst_i,
    input  logic             modify_i,
    output logic             packed_o,
    output logic [LEN_W-1:0] len_o,
    output logic [2:0]       size_o
);
    localparam int NB_LG = $clog2(NARROW_BYTES);
    localparam int SUM_W = LEN_W + NB_LG + 2;

    logic [SUM_W-1:0] byte_count;
    logic [SUM_W-1:0] span;
    logic [LEN_W-1:0] len_up;

    always_comb begin
        packed_o   = modify_i && (burst_i == BURST_INCR) && (size_i == 3'(NB_LG));
        byte_count = (SUM_W'(len_i) + SUM_W'(1)) << NB_LG;
        span       = SUM_W'(lane_i) + byte_count + SUM_W'(WIDE_BYTES - 1);
        len_up     = LEN_W'((span >> 4) - SUM_W'(1));
        len_o      = packed_o ? len_up : len_i;
        size_o     = packed_o ? WIDE_SIZE : size_i;
    end

endmodule

// File: rtl/widen_stage.sv
module widen_stage
    import axi_widen_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    stage_state_e state_q, state_d;
    logic         take;

    always_comb begin
        in_ready = (state_q == ST_EMPTY) || out_ready;
        take     = in_valid && in_ready;
        state_d  = state_q;
        unique case (state_q)
            ST_EMPTY: if (take) state_d = ST_FULL;                    // ACCEPT
            ST_FULL:  if (out_ready && !take) state_d = ST_EMPTY;     // DRAIN; else REFILL / STALL
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    out_data <= '0;
        else if (take) out_data <= in_data;
    end

    assign out_valid = (state_q == ST_FULL);

endmodule

// File: rtl/axi_cmd_widener.sv
module axi_cmd_widener
    import axi_widen_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int LEN_W        = 8,
    parameter int NARROW_BYTES = 8,
    localparam int NB_LG       = $clog2(NARROW_BYTES),
    localparam int SLOT_W      = 4 - NB_LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [LEN_W-1:0]  s_len,
    input  logic [2:0]        s_size,
    input  logic [1:0]        s_burst,
    input  logic [3:0]        s_cache,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [ADDR_W-1:0] m_addr,
    output logic [LEN_W-1:0]  m_len,
    output logic [2:0]        m_size,
    output logic [1:0]        m_burst,
    output logic [3:0]        m_cache,
    output logic              m_packed,
    output logic [3:0]        m_lane,
    output logic [SLOT_W-1:0] m_slot
);
    localparam int PAY_W = ADDR_W + LEN_W + 3 + 2 + 4 + 1;

    logic             dec_packed;
    logic [LEN_W-1:0] dec_len;
    logic [2:0]       dec_size;
    logic [PAY_W-1:0] pay_in, pay_out;

    widen_decide #(
        .LEN_W        (LEN_W),
        .NARROW_BYTES (NARROW_BYTES)
    ) u_decide (
        .lane_i   (s_addr[3:0]),
        .len_i    (s_len),
        .size_i   (s_size),
        .burst_i  (s_burst),
        .modify_i (s_cache[1]),
        .packed_o (dec_packed),
        .len_o    (dec_len),
        .size_o   (dec_size)
    );

    assign pay_in = {s_addr, dec_len, dec_size, s_burst, s_cache, dec_packed};

    widen_stage #(
        .W (PAY_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_valid),
        .in_ready  (s_ready),
        .in_data   (pay_in),
        .out_valid (m_valid),
        .out_ready (m_ready),
        .out_data  (pay_out)
    );

    assign {m_addr, m_len, m_size, m_burst, m_cache, m_packed} = pay_out;
    assign m_lane = m_addr[3:0];
    assign m_slot = m_addr[3:NB_LG];

endmodule

// File: rtl/axi_cmd_widener_chk.sv
module axi_cmd_widener_chk #(
    parameter int ADDR_W       = 32,
    parameter int LEN_W        = 8,
    parameter int NARROW_BYTES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic [LEN_W-1:0]  s_len,
    input logic [2:0]        s_size,
    input logic [1:0]        s_burst,
    input logic [3:0]        s_cache,
    input logic              m_valid,
    input logic              m_ready,
    input logic [ADDR_W-1:0] m_addr,
    input logic [LEN_W-1:0]  m_len,
    input logic [2:0]        m_size,
    input logic              m_packed,
    input logic [3:0]        m_lane
);
    localparam int NB_LG = $clog2(NARROW_BYTES);

    logic up_case;
    assign up_case = s_cache[1] && (s_burst == 2'b01) && (s_size == 3'(NB_LG));

    // R2
    upsize_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && up_case) |=> (m_packed && m_size == 3'd4));

    // R5
    expand_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !up_case) |=>
        (!m_packed && m_size == $past(s_size) && m_len == $past(s_len)));

    // R6
    lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_lane == m_addr[3:0]));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=>
        (m_valid && $stable(m_addr) && $stable(m_len) && $stable(m_size) && $stable(m_packed)));

    // R8
    accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> m_valid);

    // R9
    ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_valid || m_ready) |-> s_ready);

endmodule

bind axi_cmd_widener axi_cmd_widener_chk #(
    .ADDR_W       (ADDR_W),
    .LEN_W        (LEN_W),
    .NARROW_BYTES (NARROW_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_len    (s_len),
    .s_size   (s_size),
    .s_burst  (s_burst),
    .s_cache  (s_cache),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_addr   (m_addr),
    .m_len    (m_len),
    .m_size   (m_size),
    .m_packed (m_packed),
    .m_lane   (m_lane)
);

// File: tb/axi_cmd_widener_test.sv
`timescale 1ns/1ps
module axi_cmd_widener_test;
    localparam int NB = 4;
    localparam int AW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [AW-1:0] s_addr = '0;
    logic [LW-1:0] s_len = '0;
    logic [2:0]    s_size = '0;
    logic [1:0]    s_burst = '0;
    logic [3:0]    s_cache = '0;
    logic          m_valid;
    logic          m_ready = 1'b0;
    logic [AW-1:0] m_addr;
    logic [LW-1:0] m_len;
    logic [2:0]    m_size;
    logic [1:0]    m_burst;
    logic [3:0]    m_cache;
    logic          m_packed;
    logic [3:0]    m_lane;
    logic [1:0]    m_slot;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
        logic [2:0]    size;
        logic [1:0]    burst;
        logic [3:0]    cache;
        logic          pk;
        logic [3:0]    lane;
        logic [1:0]    slot;
    } item_t;

    item_t sbq[$];
    item_t held;
    bit    held_ok = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    int    ready_mode = 0;
    int    cyc = 0;

    always #5 clk = ~clk;

    axi_cmd_widener #(.ADDR_W(AW), .LEN_W(LW), .NARROW_BYTES(NB)) uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_addr(s_addr), .s_len(s_len), .s_size(s_size), .s_burst(s_burst),
        .s_cache(s_cache), .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr),
        .m_len(m_len), .m_size(m_size), .m_burst(m_burst), .m_cache(m_cache),
        .m_packed(m_packed), .m_lane(m_lane), .m_slot(m_slot)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic item_t model(input logic [AW-1:0] a, input logic [LW-1:0] l,
                                    input logic [2:0] sz, input logic [1:0] b, input logic [3:0] c);
        item_t e;
        int    span;
        e.addr  = a;
        e.burst = b;
        e.cache = c;
        e.lane  = a[3:0];
        e.slot  = a[3:2];
        e.pk    = c[1] && (b == 2'b01) && (sz == 3'd2);
        span    = int'(a[3:0]) + (int'(l) + 1) * NB + 15;
        e.len   = e.pk ? LW'((span >> 4) - 1) : l;
        e.size  = e.pk ? 3'd4 : sz;
        return e;
    endfunction

    function automatic item_t observed();
        item_t o;
        o = '{m_addr, m_len, m_size, m_burst, m_cache, m_packed, m_lane, m_slot};
        return o;
    endfunction

    task automatic send(input logic [AW-1:0] a, input logic [LW-1:0] l,
                        input logic [2:0] sz, input logic [1:0] b, input logic [3:0] c);
        @(negedge clk);
        s_valid = 1'b1; s_addr = a; s_len = l; s_size = sz; s_burst = b; s_cache = c;
        #1;
        if (ready_mode == 0) chk(s_ready == 1'b1, "R8 no bubble", 64'(s_ready), 64'd1);
        while (!s_ready) begin
            @(negedge clk);
            #1;
        end
        sbq.push_back(model(a, l, sz, b, c));
    endtask

    task automatic idle();
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    // Monitor: decides slave readiness, checks hold behaviour and pops the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit    r;
            item_t o, e;
            cyc++;
            r = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            m_ready = r;
            o = observed();
            if (held_ok)
                chk(m_valid && (o == held), "R7 stall hold", 64'(o.len), 64'(held.len));
            held_ok = 0;
            if (m_valid) begin
                if (r) begin
                    if (sbq.size() == 0) begin
                        chk(1'b0, "R9 unexpected command", 64'(o.addr), 64'd0);
                    end else begin
                        e = sbq.pop_front();
                        chk(o.pk == e.pk && o.size == e.size, "R2/R5 flag+size",
                            64'({o.pk, o.size}), 64'({e.pk, e.size}));
                        chk(o.len == e.len, (e.addr[3:0] == 0) ? "R3 length" : "R4 length",
                            64'(o.len), 64'(e.len));
                        chk(o.addr == e.addr && o.burst == e.burst && o.cache == e.cache &&
                            o.lane == e.lane && o.slot == e.slot, "R6 fields/order",
                            64'(o.addr), 64'(e.addr));
                    end
                end else begin
                    held = o;
                    held_ok = 1;
                end
            end
            #1;
            chk(s_ready == (!m_valid || r), "R9 ready rule", 64'(s_ready), 64'(!m_valid || r));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(m_valid == 1'b0, "R1 reset valid", 64'(m_valid), 64'd0);
        chk(s_ready == 1'b1, "R1 reset ready", 64'(s_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // Always-ready phase: back-to-back, no bubble expected.
        ready_mode = 0;
        send(32'h0000_1000, 8'd3,   3'd2, 2'b01, 4'b0010);   // R3 aligned upsize -> len 0
        send(32'h0000_1004, 8'd3,   3'd2, 2'b01, 4'b0011);   // R4 offset 4 -> len 1
        send(32'h0000_100C, 8'd0,   3'd2, 2'b01, 4'b0010);   // R4 offset 12 single beat -> len 0
        send(32'h0000_2008, 8'd7,   3'd2, 2'b01, 4'b1110);   // R4 offset 8 -> len 2
        send(32'h0000_300C, 8'd255, 3'd2, 2'b01, 4'b0010);   // R4 longest -> len 64
        send(32'h0000_4000, 8'd255, 3'd2, 2'b01, 4'b0010);   // R3 longest aligned -> len 63
        send(32'h0000_5004, 8'd5,   3'd2, 2'b01, 4'b0000);   // R5 cache bit clear
        send(32'h0000_6008, 8'd3,   3'd2, 2'b10, 4'b0010);   // R5 WRAP
        send(32'h0000_7000, 8'd9,   3'd2, 2'b00, 4'b1111);   // R5 FIXED
        send(32'h0000_8002, 8'd4,   3'd1, 2'b01, 4'b0010);   // R5 narrower size
        idle();
        repeat (4) @(negedge clk);

        // Stalling phase: slave drops ready periodically.
        ready_mode = 1;
        for (int i = 0; i < 24; i++) begin
            send(32'h0001_0000 + 32'(i * 20), 8'(i * 11), 3'(2 - (i % 3 == 2 ? 1 : 0)),
                 2'(i % 3), 4'(i % 2 ? 4'b0010 : 4'b0000));
        end
        idle();
        repeat (30) @(negedge clk);
        chk(sbq.size() == 0, "R9 all drained in order", 64'(sbq.size()), 64'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule